// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital sequencer of a 7-bit successive-approximation converter. Each clock it presents a trial code to an external DAC and reads back one comparator bit that says whether the sampled input is at least as large as that trial. The code is resolved one bit per clock, starting with the most significant bit. A full conversion takes eight clocks. The first seven clocks each decide one bit. The eighth clock shows the finished code. At the edge that closes the eighth clock, the code moves into a holding register for parallel readout.

Progress is tracked by a shift register. It is emptied at the first step and fills from the top, one position per step. The decision bits are all set to 1 when a conversion begins. The trial code exposes every decided bit plus the bit now under test, and shows zeros below it.

The block runs in one of two modes. In free-running mode, conversions follow each other back to back and a one-clock completion strobe marks each new result. In triggered mode, a rising edge on an asynchronous start input begins one conversion. A completion flag then rises and stays high until the next start edge.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After the active-low synchronous reset, and whenever the sequencer is idle, `result_o` is 0, `done_o` is 0 after reset, and `trial_o` shows only its MSB set (binary 1000000).
- R2: A conversion occupies eight consecutive clocks, steps 0 to 7. In step k (k < 7), `trial_o` carries the decided bits above position 6-k, a 1 at position 6-k, and zeros below it. In step 7, `trial_o` carries the complete decided code.
- R3: `cmp_hi_i` = 1 means the input is at least the current trial. At the end of each step 0..6, the bit under test is kept at 1 when `cmp_hi_i` is 1 and cleared to 0 when it is 0.
- R4: The loaded result is the largest 7-bit code not above the input level. Level 0 gives 0000000, full scale (127) gives 1111111, and level 44 gives 0101100 with the trial sequence 1000000, 0100000, 0110000, 0101000, 0101100, 0101110, 0101101.
- R5: `result_o` changes only at the edge that ends step 7, and at that edge it takes the finished code. In any cycle where `result_o` has just changed, `done_o` is high.
- R6: In triggered mode, `start_i` passes through a two-flop synchronizer and an edge detector. A rising edge driven before clock edge e1 starts the conversion at edge e3, so step 0 is the cycle after e3. A high `done_o` falls at that same edge e3.
- R7: In triggered mode, `done_o` is low throughout steps 0..7 and rises at the edge that loads the result. It then stays high, with the sequencer idle, until the next accepted start edge.
- R8: A start edge that arrives while a conversion is in progress is ignored. It neither restarts nor extends the conversion, and it does not cause a second conversion afterwards.
- R9: In free-running mode (`auto_mode_i` = 1), conversions run back to back with a new result every 8 clocks. `done_o` is a one-clock strobe in the step 0 that follows each load. From idle, the first strobe appears 9 clocks after `auto_mode_i` is raised.
- R10: The mode is sampled at the end of step 7. Dropping `auto_mode_i` mid-conversion lets that conversion finish, then the sequencer idles with `done_o` held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| auto_mode_i | input | 1 | 1 = free-running, 0 = triggered by start edge |
| start_i | input | 1 | Asynchronous start request, rising edge acts |
| cmp_hi_i | input | 1 | Comparator: 1 when input level >= trial code |
| trial_o | output | RES_W | Trial code driven to the DAC |
| result_o | output | RES_W | Held conversion result |
| done_o | output | 1 | Completion flag (triggered) or strobe (free-running) |

## Verification
The bench targets the extreme levels 0 and 127 and the neighbours 63 and 64, where a wrong keep/clear polarity or an off-by-one bit probe would give a code one LSB off or a stuck MSB. It follows the trial code step by step in the 44 case, so a sequencer that probes the wrong bit or exposes undecided bits is seen before the result is formed. A second start edge is driven mid-conversion: a design that fails to gate it would restart the conversion or drop the completion flag afterwards. Free-running spacing, the one-clock strobe, a mode drop mid-conversion and a reset mid-conversion cover designs that lose a cycle, keep converting, or leave stale state behind.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;

   function automatic int unsigned step_count(input int unsigned res_w);
      return res_w + 1;
   endfunction

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic pulse_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sar_start_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], start_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   // one-cycle pulse on a synchronized low-to-high transition
   assign pulse_o = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/sar_bit_slices.sv
module sar_bit_slices #(
   parameter int unsigned W = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clear_i,
   input  logic         advance_i,
   input  logic         cmp_hi_i,
   output logic [W-1:0] reach_o,
   output logic [W-1:0] code_o,
   output logic [W-1:0] trial_o,
   output logic         full_o
);

   logic [W-1:0] probe;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         logic upper;
         logic reach_q;
         logic keep_q;

         if (i == W - 1) begin : g_top
            assign upper = 1'b1;
         end else begin : g_lower
            assign upper = reach_o[i+1];
         end

         // position under test: first position the token has not reached
         assign probe[i] = upper & ~reach_q;

         always_ff @(posedge clk_i) begin
            if (!rst_ni || clear_i) begin
               reach_q <= 1'b0;
               keep_q  <= 1'b1;
            end else if (advance_i) begin
               reach_q <= upper;
               if (probe[i] && !cmp_hi_i) begin
                  keep_q <= 1'b0;
               end
            end
         end

         assign reach_o[i] = reach_q;
         assign code_o[i]  = keep_q;
         assign trial_o[i] = keep_q & (reach_q | probe[i]);
      end
   endgenerate

   assign full_o = &reach_o;

endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
   parameter int unsigned W = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic         drop_i,
   input  logic [W-1:0] code_i,
   output logic [W-1:0] result_o,
   output logic         done_o
);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         result_o <= '0;
         done_o   <= 1'b0;
      end else if (load_i) begin
         result_o <= code_i;
         done_o   <= 1'b1;
      end else if (drop_i) begin
         done_o   <= 1'b0;
      end
   end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
   import sar_pkg::*;
#(
   parameter int unsigned RES_W       = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             auto_mode_i,
   input  logic             start_i,
   input  logic             cmp_hi_i,
   output logic [RES_W-1:0] trial_o,
   output logic [RES_W-1:0] result_o,
   output logic             done_o
);

   localparam int unsigned STEPS = step_count(RES_W);

   generate
      if (RES_W < 2) begin : g_bad_width
         $error("sar_seq_ctrl: RES_W must be at least 2");
      end
      if (STEPS != RES_W + 1) begin : g_bad_steps
         $error("sar_seq_ctrl: step count mismatch");
      end
   endgenerate

   seq_state_e       state_q;
   logic             running;
   logic             start_pulse;
   logic             go;
   logic             full;
   logic             last_step;
   logic             advance;
   logic             clear;
   logic             drop;
   logic [RES_W-1:0] reach;
   logic [RES_W-1:0] code;

   sar_start_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start_i),
      .pulse_o (start_pulse)
   );

   assign running   = (state_q == SEQ_RUN);
   assign go        = ~running & (auto_mode_i | start_pulse);
   assign last_step = running & full;
   assign advance   = running & ~full;
   assign clear     = ~running | last_step;
   assign drop      = go | (running & ~last_step);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
      end else begin
         unique case (state_q)
            SEQ_IDLE: if (go) state_q <= SEQ_RUN;
            SEQ_RUN:  if (last_step && !auto_mode_i) state_q <= SEQ_IDLE;
            default:  state_q <= SEQ_IDLE;
         endcase
      end
   end

   sar_bit_slices #(
      .W (RES_W)
   ) u_bits (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clear_i   (clear),
      .advance_i (advance),
      .cmp_hi_i  (cmp_hi_i),
      .reach_o   (reach),
      .code_o    (code),
      .trial_o   (trial_o),
      .full_o    (full)
   );

   sar_result_hold #(
      .W (RES_W)
   ) u_hold (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (last_step),
      .drop_i   (drop),
      .code_i   (code),
      .result_o (result_o),
      .done_o   (done_o)
   );

endmodule

// File: rtl/sar_seq_ctrl_chk.sv
module sar_seq_ctrl_chk #(
   parameter int unsigned RES_W = 7
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             auto_mode_i,
   input logic             cmp_hi_i,
   input logic [RES_W-1:0] trial_o,
   input logic [RES_W-1:0] result_o,
   input logic             done_o,
   input logic             running_i,
   input logic [RES_W-1:0] reach_i,
   input logic             start_pulse_i
);

   localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

   logic full;
   assign full = &reach_i;

   p_idle_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !running_i |-> trial_o == MSB_ONLY);

   p_single_probe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_i && !full) |-> $countones(trial_o & ~reach_i) == 1);

   p_clear_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_i && !full && !cmp_hi_i) |=> (trial_o & $past(trial_o & ~reach_i)) == '0);

   p_keep_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_i && !full && cmp_hi_i) |=>
         (trial_o & $past(trial_o & ~reach_i)) == $past(trial_o & ~reach_i));

   p_result_on_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(result_o) |-> done_o);

   p_flag_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!auto_mode_i && done_o && !running_i && !start_pulse_i) |=> done_o);

   p_ignore_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_i && !full) |=> running_i);

   p_strobe_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && running_i) |=> !done_o);

   p_stop_manual_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (running_i && full && !auto_mode_i) |=> (!running_i && done_o));

endmodule

bind sar_seq_ctrl sar_seq_ctrl_chk #(
   .RES_W (RES_W)
) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .auto_mode_i   (auto_mode_i),
   .cmp_hi_i      (cmp_hi_i),
   .trial_o       (trial_o),
   .result_o      (result_o),
   .done_o        (done_o),
   .running_i     (running),
   .reach_i       (reach),
   .start_pulse_i (start_pulse)
);

// File: tb/sar_seq_ctrl_tb_top.sv
module sar_seq_ctrl_tb_top;

   localparam int W = 7;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         auto_mode;
   logic         start;
   logic         cmp_hi;
   logic [W-1:0] trial;
   logic [W-1:0] result;
   logic         done;
   int           level;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_q[$];
   bit finished = 1'b0;
   logic prev_done = 1'b0;
   int   exp_v;

   always #10 clk = ~clk;

   // ideal DAC + comparator: high when input level >= trial code
   assign cmp_hi = (level >= int'(trial));

   sar_seq_ctrl #(.RES_W(W), .SYNC_STAGES(2)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .auto_mode_i (auto_mode),
      .start_i     (start),
      .cmp_hi_i    (cmp_hi),
      .trial_o     (trial),
      .result_o    (result),
      .done_o      (done)
   );

   task automatic check_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // expected trial code in a given step, from the bit-by-bit search rule
   function automatic int exp_trial(input int lvl, input int step);
      int code = 0;
      for (int k = 0; k < step; k++) begin
         int t = code | (1 << (W - 1 - k));
         if (lvl >= t) code = t;
      end
      if (step < W) return code | (1 << (W - 1 - step));
      return code;
   endfunction

   // scoreboard monitor: each completion pops one expected result
   always @(negedge clk) begin
      if (rst_n && done && !prev_done) begin
         if (exp_q.size() == 0) begin
            check_eq("R4 unexpected completion", 1, 0);
         end else begin
            exp_v = exp_q.pop_front();
            check_eq("R4 result vs largest code not above level", int'(result), exp_v);
         end
      end
      prev_done = done;
   end

   task automatic manual_trace(input int lvl, input bit glitch);
      bit was_done;
      level = lvl;
      start = 1'b0;
      wait_neg(3);
      was_done = done;
      exp_q.push_back(lvl);
      start = 1'b1;
      wait_neg(2);
      if (was_done) check_eq("R6 flag held until synchronized start acts", int'(done), 1);
      wait_neg(1);
      for (int step = 0; step <= W; step++) begin
         if (step > 0) wait_neg(1);
         check_eq("R2 trial code per step", int'(trial), exp_trial(lvl, step));
         check_eq("R7 flag low while converting", int'(done), 0);
         if (glitch && step == 1) start = 1'b0;
         if (glitch && step == 3) start = 1'b1;
         if (!glitch && step == 2) start = 1'b0;
      end
      wait_neg(1);
      check_eq("R7 flag rises at completion", int'(done), 1);
      check_eq("R5 result loaded after step 7", int'(result), lvl);
      wait_neg(10);
      if (glitch) begin
         check_eq("R8 late start edge ignored, flag kept", int'(done), 1);
         check_eq("R8 late start edge ignored, result kept", int'(result), lvl);
      end else begin
         check_eq("R7 flag held while idle", int'(done), 1);
         check_eq("R5 result stable while idle", int'(result), lvl);
      end
      start = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R2 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int lv[5];
      int c;
      int idx;
      logic p;
      lv[0] = 17; lv[1] = 100; lv[2] = 0; lv[3] = 127; lv[4] = 85;

      rst_n = 1'b0; auto_mode = 1'b0; start = 1'b0; level = 0;
      wait_neg(3);
      check_eq("R1 reset result", int'(result), 0);
      check_eq("R1 reset flag", int'(done), 0);
      check_eq("R1 reset trial", int'(trial), 64);
      rst_n = 1'b1;
      wait_neg(5);
      check_eq("R1 idle without start: flag", int'(done), 0);
      check_eq("R1 idle without start: trial", int'(trial), 64);

      // triggered conversions, including the 44 example and both extremes
      manual_trace(44, 1'b0);
      check_eq("R4 example code 0101100", int'(result), 7'b0101100);
      manual_trace(0, 1'b0);
      manual_trace(127, 1'b0);
      check_eq("R4 full scale gives all ones", int'(result), 7'b1111111);
      manual_trace(64, 1'b0);
      manual_trace(63, 1'b1);
      manual_trace(126, 1'b0);

      // free-running: back-to-back conversions, new level after each strobe
      c = 0; idx = 0; p = done;
      level = lv[0];
      exp_q.push_back(lv[0]);
      auto_mode = 1'b1;
      while (idx < 5) begin
         wait_neg(1);
         c++;
         if (p) begin
            check_eq("R9 one-cycle strobe", int'(done), 0);
         end else if (done) begin
            check_eq("R9 result spacing", c, (idx == 0) ? 9 : 8);
            idx++;
            if (idx < 5) begin
               level = lv[idx];
               exp_q.push_back(lv[idx]);
            end else begin
               auto_mode = 1'b0;
               level = 33;
               exp_q.push_back(33);
            end
            c = 0;
         end
         p = done;
      end
      // mode dropped in step 0: conversion finishes, then idles
      while (!(done && !p)) begin
         p = done;
         wait_neg(1);
         c++;
      end
      check_eq("R10 running conversion completes", c, 8);
      wait_neg(12);
      check_eq("R10 idle with flag high after mode drop", int'(done), 1);
      check_eq("R10 result of last conversion", int'(result), 33);

      // reset in mid-conversion
      level = 90;
      start = 1'b0;
      wait_neg(3);
      start = 1'b1;
      wait_neg(6);
      rst_n = 1'b0;
      start = 1'b0;
      wait_neg(2);
      check_eq("R1 reset mid-conversion result", int'(result), 0);
      check_eq("R1 reset mid-conversion flag", int'(done), 0);
      check_eq("R1 reset mid-conversion trial", int'(trial), 64);
      rst_n = 1'b1;
      wait_neg(4);
      check_eq("R1 idle after reset", int'(trial), 64);
      manual_trace(1, 1'b0);

      wait_neg(2);
      check_eq("R4 every expected result delivered", exp_q.size(), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule